// File: doc/BRIEF.md
# Expansion Bus Cycle Sequencer

This block runs one transfer at a time on an 8-bit expansion channel. A requester on the processor side asks for a memory cycle, an I/O cycle or a DMA transfer, in a read or a write direction. The sequencer then holds a 20-bit address on the channel, drives or releases an 8-bit bidirectional data bus, and asserts the matching active-low read or write strobes. Memory and I/O have separate strobes. A memory cycle lasts four clocks. An I/O cycle or a DMA transfer lasts five. A slow card can add whole wait clocks by holding the ready input low.

The block also watches an error input driven by the expansion cards, such as a memory board reporting a parity error. It turns the first rising edge of that input into a sticky non-maskable interrupt request. The request holds until software clears it, so a one-clock error pulse is never lost.

Cycle timing, counted in clocks while `busy_o` is high: clock 1 puts out the address and, for a write, the data. Strobes are asserted from clock 2 through the final clock. The read byte is captured on the edge that ends the final clock. `done_o` pulses in the clock after that.

Top module: `xbus_cycle_seq`

## Requirements
- R1: While `busy_o` is high, `bus_addr_o` holds the address captured with the request. For CPU writes (kind 0 or 1 with `wr_i`=1), `bus_data_io` carries the write byte in every clock of the cycle. The bus is not driven otherwise.
- R2: Kind 0 (memory) with no waits keeps `busy_o` high for 4 clocks. `mem_rd_no` (for `wr_i`=0) or `mem_wr_no` (for `wr_i`=1) is low in clocks 2 to 4. All other strobes stay high.
- R3: Kind 1 (I/O) with no waits keeps `busy_o` high for 5 clocks. `io_rd_no` or `io_wr_no` is low in clocks 2 to 5.
- R4: Kind 2 (DMA) lasts 5 clocks. With `wr_i`=1 (memory to device), `mem_rd_no` and `io_wr_no` are low together. With `wr_i`=0 (device to memory), `io_rd_no` and `mem_wr_no` are low together. Both are low in clocks 2 to 5, and the sequencer never drives the data bus during a DMA transfer.
- R5: `ready_i` is sampled on the edge that ends clock N-1, where N is the base length. Each edge at which it is low adds one wait clock with the strobes held. The final clock follows the first edge at which it is high, and `done_o` pulses for one clock after the cycle.
- R6: A CPU read (kind 0 or 1 with `wr_i`=0) loads `rdata_o` with the bus byte present at the edge that ends the final clock. Writes and DMA transfers leave `rdata_o` unchanged.
- R7: An I/O request whose address bits [9:0] are below 0x100, or any request with kind 3, starts no cycle and drives no strobe. Instead `reject_o` pulses in the next clock. I/O addresses 0x100 to 0x3FF are accepted.
- R8: A request raised while `busy_o` is high is ignored, and no cycle follows it.
- R9: A rising edge on `chan_chk_i` sets `nmi_o` from the next clock on. `nmi_o` holds until `nmi_clr_i`. A rising edge in the same clock as the clear wins. A level that stays high does not set it again.
- R10: During and after reset, `busy_o`, `done_o`, `reject_o` and `nmi_o` are low, all strobes are high, and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request, taken when idle |
| kind_i | input | 2 | 0 memory, 1 I/O, 2 DMA, 3 invalid |
| wr_i | input | 1 | Direction: 1 write (DMA: memory to device) |
| addr_i | input | 20 | Request address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock pulse after a cycle ends |
| reject_o | output | 1 | One-clock pulse for a refused request |
| rdata_o | output | 8 | Last byte read by the CPU |
| bus_addr_o | output | 20 | Channel address |
| bus_data_io | inout | 8 | Channel data bus |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| ready_i | input | 1 | Channel ready; low inserts wait clocks |
| chan_chk_i | input | 1 | Card error report |
| nmi_clr_i | input | 1 | Clears the interrupt request |
| nmi_o | output | 1 | Sticky non-maskable interrupt request |

## Verification
The bench sweeps every kind and direction against zero to three wait clocks and checks the strobes, address, data and busy state in every clock. An off-by-one ready sample would shift the wait count, and a wrong base length would end a cycle early or late. The reserved I/O boundary is probed at 0x0FF, 0x100, 0x3FF and a wrapped 0x400: a decoder that compared too many or too few address bits would start a cycle or refuse one. Reads are followed by writes and DMA transfers, which would expose a capture register that also loads outside CPU reads. A request raised mid-cycle would show up as a second cycle. Tests of the error latch cover a one-clock pulse, a held level after clear, and a clear in the same clock as an edge, which catch level-triggered or clear-first latches.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    K_MEM = 2'd0,
    K_IO  = 2'd1,
    K_DMA = 2'd2,
    K_BAD = 2'd3
  } kind_e;
endpackage

// File: rtl/xbus_timer.sv
module xbus_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             ready_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] len_o,
  output logic             finish_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q, len_q;
  logic             at_last, at_sample;

  assign at_last   = (cnt_q == len_q);
  assign at_sample = (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(1);
      len_q    <= len_i;
    end else if (active_q) begin
      if (at_last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (!(at_sample && !ready_i)) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign len_o    = len_q;
  assign finish_o = active_q && at_last;
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
  import xbus_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  kind_e            kind_i,
  input  logic             wr_i,
  output logic             mem_rd_no,
  output logic             mem_wr_no,
  output logic             io_rd_no,
  output logic             io_wr_no,
  output logic             data_oe_o
);
  logic on;
  assign on = active_i && (cnt_i >= CNT_W'(2));

  always_comb begin
    mem_rd_no = 1'b1;
    mem_wr_no = 1'b1;
    io_rd_no  = 1'b1;
    io_wr_no  = 1'b1;
    if (on) begin
      unique case (kind_i)
        K_MEM: begin
          mem_rd_no = wr_i;
          mem_wr_no = !wr_i;
        end
        K_IO: begin
          io_rd_no = wr_i;
          io_wr_no = !wr_i;
        end
        K_DMA: begin
          // wr: memory to device, else device to memory
          mem_rd_no = !wr_i;
          io_wr_no  = !wr_i;
          io_rd_no  = wr_i;
          mem_wr_no = wr_i;
        end
        default: ;
      endcase
    end
  end

  assign data_oe_o = active_i && wr_i && (kind_i == K_MEM || kind_i == K_IO);
endmodule

// File: rtl/xbus_nmi_latch.sv
module xbus_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_i,
  input  logic clr_i,
  output logic nmi_o
);
  logic chk_q, nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      chk_q <= chk_i;
      if (chk_i && !chk_q) nmi_q <= 1'b1;  // set beats clear
      else if (clr_i)      nmi_q <= 1'b0;
    end
  end

  assign nmi_o = nmi_q;
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int MEM_CLKS   = 4,
  parameter int IO_CLKS    = 5,
  parameter int DMA_CLKS   = 5,
  parameter int IO_DEC_W   = 10,
  parameter int IO_RSV_LIM = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              reject_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  inout  wire  [DATA_W-1:0] bus_data_io,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  input  logic              ready_i,
  input  logic              chan_chk_i,
  input  logic              nmi_clr_i,
  output logic              nmi_o
);
  localparam int MAX_A  = (MEM_CLKS > IO_CLKS) ? MEM_CLKS : IO_CLKS;
  localparam int MAX_CL = (MAX_A > DMA_CLKS) ? MAX_A : DMA_CLKS;
  localparam int CNT_W  = $clog2(MAX_CL + 1);
  localparam logic [IO_DEC_W-1:0] RSV_LIM = IO_DEC_W'(IO_RSV_LIM);

  kind_e             kind_in, kind_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q, rej_q;
  logic              active, finish, start, bad, data_oe;
  logic [CNT_W-1:0]  len_sel, cyc_cnt, cyc_len;

  assign kind_in = kind_e'(kind_i);
  assign bad     = (kind_in == K_BAD) ||
                   (kind_in == K_IO && addr_i[IO_DEC_W-1:0] < RSV_LIM);
  assign start   = req_i && !active && !bad;

  always_comb begin
    unique case (kind_in)
      K_MEM:   len_sel = CNT_W'(MEM_CLKS);
      K_IO:    len_sel = CNT_W'(IO_CLKS);
      default: len_sel = CNT_W'(DMA_CLKS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= K_MEM;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      done_q <= finish;
      rej_q  <= req_i && !active && bad;
      if (start) begin
        kind_q  <= kind_in;
        wr_q    <= wr_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (finish && !wr_q && kind_q != K_DMA) rdata_q <= bus_data_io;
    end
  end

  xbus_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .len_i    (len_sel),
    .ready_i  (ready_i),
    .active_o (active),
    .cnt_o    (cyc_cnt),
    .len_o    (cyc_len),
    .finish_o (finish)
  );

  xbus_strobe_dec #(.CNT_W(CNT_W)) u_dec (
    .active_i  (active),
    .cnt_i     (cyc_cnt),
    .kind_i    (kind_q),
    .wr_i      (wr_q),
    .mem_rd_no (mem_rd_no),
    .mem_wr_no (mem_wr_no),
    .io_rd_no  (io_rd_no),
    .io_wr_no  (io_wr_no),
    .data_oe_o (data_oe)
  );

  xbus_nmi_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chk_i  (chan_chk_i),
    .clr_i  (nmi_clr_i),
    .nmi_o  (nmi_o)
  );

  assign bus_data_io = data_oe ? wdata_q : {DATA_W{1'bz}};
  assign bus_addr_o  = addr_q;
  assign busy_o      = active;
  assign done_o      = done_q;
  assign reject_o    = rej_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/xbus_cycle_seq_chk.sv
module xbus_cycle_seq_chk #(
  parameter int ADDR_W   = 20,
  parameter int IO_DEC_W = 10,
  parameter int CNT_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        kind_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_i,
  input logic              chan_chk_i,
  input logic              nmi_clr_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              reject_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              mem_rd_no,
  input logic              mem_wr_no,
  input logic              io_rd_no,
  input logic              io_wr_no,
  input logic              nmi_o,
  input logic [CNT_W-1:0]  cyc_cnt,
  input logic [CNT_W-1:0]  cyc_len
);
  assert_strb_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_rd_no && !mem_wr_no) && !(!io_rd_no && !io_wr_no));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_rd_no && mem_wr_no && io_rd_no && io_wr_no));

  assert_wait_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cyc_cnt == cyc_len - CNT_W'(1) && !ready_i) |=> (busy_o && $stable(cyc_cnt)));

  assert_end_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_addr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cyc_cnt != cyc_len) |=> (busy_o && $stable(bus_addr_o)));

  assert_rsv_io_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && kind_i == 2'd1 && addr_i[IO_DEC_W-1:8] == '0) |=> (!busy_o && reject_o));

  assert_nmi_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_chk_i) |=> nmi_o);

  assert_nmi_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_o && !nmi_clr_i) |=> nmi_o);
endmodule

bind xbus_cycle_seq xbus_cycle_seq_chk #(
  .ADDR_W   (ADDR_W),
  .IO_DEC_W (IO_DEC_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .kind_i     (kind_i),
  .addr_i     (addr_i),
  .ready_i    (ready_i),
  .chan_chk_i (chan_chk_i),
  .nmi_clr_i  (nmi_clr_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .reject_o   (reject_o),
  .bus_addr_o (bus_addr_o),
  .mem_rd_no  (mem_rd_no),
  .mem_wr_no  (mem_wr_no),
  .io_rd_no   (io_rd_no),
  .io_wr_no   (io_wr_no),
  .nmi_o      (nmi_o),
  .cyc_cnt    (cyc_cnt),
  .cyc_len    (cyc_len)
);

// File: tb/test_xbus_cycle_seq.sv
`timescale 1ns/1ps
module test_xbus_cycle_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic        wr_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_i = 1'b1;
  logic        chan_chk_i = 1'b0;
  logic        nmi_clr_i = 1'b0;
  logic        busy_o, done_o, reject_o, nmi_o;
  logic [7:0]  rdata_o;
  logic [19:0] bus_addr_o;
  logic        mem_rd_no, mem_wr_no, io_rd_no, io_wr_no;
  wire  [7:0]  bus_data;
  logic        tb_rd_en = 1'b0;
  logic [7:0]  tb_byte = '0;

  int nvec = 0;
  int nfail = 0;
  logic [7:0] rdata_exp = '0;

  always #4 clk_i = ~clk_i;

  assign bus_data = (tb_rd_en && (!io_rd_no || !mem_rd_no)) ? tb_byte : 8'bz;

  xbus_cycle_seq i_xbus_cycle_seq (
    .clk_i, .rst_ni, .req_i, .kind_i, .wr_i, .addr_i, .wdata_i,
    .busy_o, .done_o, .reject_o, .rdata_o, .bus_addr_o,
    .bus_data_io (bus_data),
    .mem_rd_no, .mem_wr_no, .io_rd_no, .io_wr_no,
    .ready_i, .chan_chk_i, .nmi_clr_i, .nmi_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {busy, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}
  function automatic logic [4:0] exp_strb(input int k, input bit w, input bit busy, input bit on);
    logic mr, mw, ir, iw;
    mr = on && ((k == 0 && !w) || (k == 2 && w));
    mw = on && ((k == 0 && w) || (k == 2 && !w));
    ir = on && ((k == 1 && !w) || (k == 2 && !w));
    iw = on && ((k == 1 && w) || (k == 2 && w));
    return {busy, !mr, !mw, !ir, !iw};
  endfunction

  function automatic logic [4:0] act_strb();
    return {busy_o, mem_rd_no, mem_wr_no, io_rd_no, io_wr_no};
  endfunction

  task automatic run_cycle(input int k, input bit w, input logic [19:0] a,
                           input logic [7:0] d, input int waits, input bit poke);
    int last, total;
    string tag;
    last  = (k == 0) ? 4 : 5;
    total = last + waits;
    tag   = (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
    @(negedge clk_i);
    req_i = 1'b1; kind_i = 2'(k); wr_i = w; addr_i = a; wdata_i = d;
    tb_byte = d ^ 8'h5A; tb_rd_en = !w;
    for (int j = 1; j <= total; j++) begin
      @(negedge clk_i);
      if (j == 1) begin
        req_i = poke;
        kind_i = 2'((k + 1) % 3);
        addr_i = a ^ 20'h00F0F;
      end else if (j == 2) req_i = 1'b0;
      chk((waits > 0 && j >= last) ? "R5" : tag, act_strb(), exp_strb(k, w, 1'b1, j >= 2));
      chk("R1", bus_addr_o, a);
      if (w && k != 2) chk("R1", bus_data, d);
      ready_i = !(j >= last - 1 && j < last - 1 + waits);
    end
    @(negedge clk_i);
    ready_i = 1'b1;
    chk(waits > 0 ? "R5" : tag, act_strb(), exp_strb(k, w, 1'b0, 1'b0));
    chk("R5", done_o, 1);
    if (!w && k != 2) rdata_exp = d ^ 8'h5A;
    chk("R6", rdata_o, rdata_exp);
    tb_rd_en = 1'b0;
    if (poke) begin
      @(negedge clk_i);
      chk("R8", act_strb(), exp_strb(0, 0, 1'b0, 1'b0));
      @(negedge clk_i);
      chk("R8", busy_o, 0);
    end
  endtask

  task automatic try_reject(input int k, input logic [19:0] a);
    @(negedge clk_i);
    req_i = 1'b1; kind_i = 2'(k); wr_i = 1'b1; addr_i = a; wdata_i = 8'hC3;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R7", act_strb(), exp_strb(0, 0, 1'b0, 1'b0));
    chk("R7", reject_o, 1);
    @(negedge clk_i);
    chk("R7", busy_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10", act_strb(), exp_strb(0, 0, 1'b0, 1'b0));
    chk("R10", {done_o, reject_o, nmi_o}, 0);
    chk("R10", rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", act_strb(), exp_strb(0, 0, 1'b0, 1'b0));

    for (int k = 0; k < 3; k++)
      for (int w = 0; w < 2; w++)
        for (int n = 0; n < 4; n++)
          run_cycle(k, w[0], 20'h3C300 | 20'(k << 4) | 20'(w << 3) | 20'(n),
                    8'(8'h11 * (k * 8 + w * 4 + n + 1)), n, 1'b0);

    // I/O decode boundary
    try_reject(1, 20'h000FF);
    try_reject(1, 20'hABC00);
    try_reject(3, 20'h3C300);
    run_cycle(1, 1'b0, 20'h00100, 8'h7E, 0, 1'b0);
    run_cycle(1, 1'b1, 20'h003FF, 8'h81, 1, 1'b0);

    // mid-cycle request must be dropped
    run_cycle(0, 1'b1, 20'hF0123, 8'h3C, 0, 1'b1);
    run_cycle(2, 1'b0, 20'h12345, 8'h96, 2, 1'b1);
    chk("R6", rdata_o, rdata_exp);

    // error latch
    chk("R9", nmi_o, 0);
    chan_chk_i = 1'b1;
    @(negedge clk_i);
    chan_chk_i = 1'b0;
    chk("R9", nmi_o, 1);
    repeat (3) begin
      @(negedge clk_i);
      chk("R9", nmi_o, 1);
    end
    chan_chk_i = 1'b1;
    nmi_clr_i  = 1'b1;
    @(negedge clk_i);
    nmi_clr_i = 1'b0;
    chk("R9", nmi_o, 1);
    nmi_clr_i = 1'b1;
    @(negedge clk_i);
    nmi_clr_i = 1'b0;
    chk("R9", nmi_o, 0);
    repeat (3) begin
      @(negedge clk_i);
      chk("R9", nmi_o, 0);
    end
    chan_chk_i = 1'b0;
    @(negedge clk_i);
    chk("R9", nmi_o, 0);
    chan_chk_i = 1'b1;
    nmi_clr_i  = 1'b1;
    @(negedge clk_i);
    chan_chk_i = 1'b0;
    nmi_clr_i  = 1'b0;
    chk("R9", nmi_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule